// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Byte Receiver

This block takes one asynchronous serial line and turns every frame on it into a parallel byte for a processor-side bus. When nothing is being sent the line sits high. A frame is the start bit (low), eight data bits sent least significant bit first, one even-parity bit and one stop bit (high). An internal divider derives a sample tick at sixteen times the bit rate from the system clock. The receiver passes the line through a two-stage synchroniser and watches it on every tick for a start bit.

Once a start bit is seen, two 4-bit counters run the frame. The sample counter gives the position inside the current bit. The bit-index counter gives which bit of the frame is on the line. Each bit is sampled at its middle. Data bits go into a shift register that moves left. The parity bit is compared with the data, and the stop bit is tested for the idle level. The finished byte and its two error flags are then copied into a holding buffer and announced with a one-cycle valid pulse. The shift register is then free for the next frame, while the processor reads the held byte at its own pace.

Top module: `async_byte_rx`

## Requirements
- R1: While reset is asserted and after it is released, rxValid, parityErr and frameErr are 0 and rxData is all zeros until the first frame completes.
- R2: The serial input passes through two flip-flops. With the receiver idle, a low level on that synchronised line at a sample tick starts a frame.
- R3: The sample counter runs 0 to 15 within each bit, and 7 is its middle. The bit-index counter is 0 for the start bit, 1 to 8 for the data bits, 9 for parity and 10 for stop. It advances when the sample counter wraps from 15 to 0.
- R4: Each data bit is sampled at sample count 7. The first data bit received is the least significant, so it appears on rxData[0] and the last appears on rxData[7].
- R5: Parity is even. parityErr is 1 exactly when the eight data bits plus the parity bit hold an odd number of ones.
- R6: A stop bit sampled low sets frameErr to 1 in the same cycle as the valid pulse. A high stop bit sets frameErr to 0.
- R7: If the line is high again at the middle of the start bit, the receiver returns to idle with no valid pulse, and rxData and the flags keep their values.
- R8: rxValid is a single-cycle pulse. rxData, parityErr and frameErr change only in the cycle rxValid is 1, and they hold until the next pulse.
- R9: The sample tick comes once every CLK_HZ/(BIT_RATE*16) clock cycles, so one bit lasts 16 ticks at the configured bit rate.
- R10: The receiver is ready for a new start bit from the middle of the stop bit onward. Frames sent with no idle time between them are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| rxData | output | DATA_BITS | Held received byte |
| rxValid | output | 1 | One-cycle pulse when a new byte is loaded |
| parityErr | output | 1 | Even-parity mismatch for the held byte |
| frameErr | output | 1 | Stop bit was low for the held byte |

## Verification
The properties assume that the serial line keeps each level for about a whole bit period at the configured rate, and that frames never arrive so fast that a valid pulse could fall on two cycles in a row. Sixteen ticks per bit always keep pulses far apart. The stimulus drives the line only on falling clock edges and holds every bit for exactly 16 divider periods. The only deliberately short pulses are a start glitch lasting a few ticks and a low stop bit that stays low just past its midpoint. Both are still clearly longer than one sample tick, so every line level the properties reason about is seen on at least one tick.

// File: rtl/async_byte_rx_pkg.sv
package async_byte_rx_pkg;

  localparam int OVERSAMPLE = 16;
  localparam int CNT_W      = 4;

  typedef struct packed {
    logic startFrame;
    logic shiftBit;
    logic checkParity;
    logic finishFrame;
  } rxStrobe_t;

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV = 813
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == LAST) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/rx_control.sv
module rx_control
  import async_byte_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lineSync,
  output rxStrobe_t        strobe,
  output logic [CNT_W-1:0] sampleIdx,
  output logic [CNT_W-1:0] bitIdx
);
  localparam logic [CNT_W-1:0] MID      = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(DATA_BITS + 2);

  typedef enum logic {ST_IDLE, ST_FRAME} rxState_t;
  rxState_t state;
  logic abortFrame;

  always_comb begin
    strobe     = '0;
    abortFrame = 1'b0;
    if (tick) begin
      if (state == ST_IDLE) begin
        strobe.startFrame = !lineSync;
      end else if (sampleIdx == MID) begin
        if (bitIdx == '0)           abortFrame         = lineSync;
        else if (bitIdx <= DATA_END) strobe.shiftBit    = 1'b1;
        else if (bitIdx == PAR_IDX)  strobe.checkParity = 1'b1;
        else if (bitIdx == STOP_IDX) strobe.finishFrame = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sampleIdx <= '0;
      bitIdx    <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        sampleIdx <= '0;
        bitIdx    <= '0;
        if (strobe.startFrame) state <= ST_FRAME;
      end else if (abortFrame || strobe.finishFrame) begin
        state     <= ST_IDLE;
        sampleIdx <= '0;
        bitIdx    <= '0;
      end else if (sampleIdx == LAST) begin
        sampleIdx <= '0;
        bitIdx    <= bitIdx + 1'b1;
      end else begin
        sampleIdx <= sampleIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import async_byte_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  rxStrobe_t            strobe,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr
);
  logic [1:0]           syncQ;
  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] shiftRev;
  logic                 parPend;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serialIn};
  end
  assign lineSync = syncQ[1];

  // first bit in ends up at the top of a left shifter; reverse on load
  generate
    for (genvar i = 0; i < DATA_BITS; i++) begin : g_rev
      assign shiftRev[i] = shiftReg[DATA_BITS-1-i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parPend  <= 1'b0;
    end else begin
      if (strobe.startFrame) parPend <= 1'b0;
      if (strobe.shiftBit) shiftReg <= {shiftReg[DATA_BITS-2:0], lineSync};
      if (strobe.checkParity) parPend <= (^shiftReg) ^ lineSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxValid <= strobe.finishFrame;
      if (strobe.finishFrame) begin
        rxData    <= shiftRev;
        parityErr <= parPend;
        frameErr  <= !lineSync;
      end
    end
  end
endmodule

// File: rtl/async_byte_rx.sv
module async_byte_rx
  import async_byte_rx_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int BIT_RATE  = 9600,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr
);
  localparam int TICK_DIV = CLK_HZ / (BIT_RATE * OVERSAMPLE);

  logic             tick;
  logic             lineSync;
  rxStrobe_t        strobe;
  logic [CNT_W-1:0] sampleIdx;
  logic [CNT_W-1:0] bitIdx;

  rx_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  rx_control #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineSync(lineSync),
    .strobe(strobe), .sampleIdx(sampleIdx), .bitIdx(bitIdx)
  );

  rx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .strobe(strobe),
    .lineSync(lineSync), .rxData(rxData), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr)
  );
endmodule

// File: rtl/async_byte_rx_chk.sv
module async_byte_rx_chk
  import async_byte_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxValid,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 parityErr,
  input logic                 frameErr,
  input rxStrobe_t            strobe,
  input logic [CNT_W-1:0]     sampleIdx,
  input logic [CNT_W-1:0]     bitIdx
);
  localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(DATA_BITS + 2);

  logic [CNT_W-1:0] shiftsSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                  shiftsSeen <= '0;
    else if (strobe.startFrame) shiftsSeen <= '0;
    else if (strobe.shiftBit)   shiftsSeen <= shiftsSeen + 1'b1;
  end

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxData) && $stable(parityErr) && $stable(frameErr)));

  a_r3_index_range: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= STOP_IDX);

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx != $past(bitIdx)) |-> (bitIdx == '0 || $past(sampleIdx) == 4'hF));

  a_r6_finish_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finishFrame |=> rxValid);

  a_r4_all_bits_shifted: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finishFrame |-> (shiftsSeen == CNT_W'(DATA_BITS)));

  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.shiftBit, strobe.checkParity, strobe.finishFrame}));
endmodule

bind async_byte_rx async_byte_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
  .parityErr(parityErr), .frameErr(frameErr), .strobe(strobe),
  .sampleIdx(sampleIdx), .bitIdx(bitIdx)
);

// File: tb/sim_async_byte_rx.sv
module sim_async_byte_rx;
  localparam int BIT_RATE = 9600;
  localparam int DIV      = 4;
  localparam int CLK_HZ   = BIT_RATE * 16 * DIV;
  localparam int BITCLK   = 16 * DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic [7:0] rxData;
  logic       rxValid, parityErr, frameErr;

  int checks = 0, errors = 0;
  int validCount = 0, widthErrs = 0, holdErrs = 0;
  logic [7:0] lastData = 8'h00;
  logic lastPar = 1'b0, lastFrm = 1'b0, prevValid = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  async_byte_rx #(.CLK_HZ(CLK_HZ), .BIT_RATE(BIT_RATE), .DATA_BITS(8)) u0 (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .rxData(rxData),
    .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        validCount++;
        if (prevValid) widthErrs++;
        lastData = rxData; lastPar = parityErr; lastFrm = frameErr;
      end else if (rxData !== lastData || parityErr !== lastPar || frameErr !== lastFrm) begin
        holdErrs++;
      end
      prevValid = rxValid;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic driveBits(input logic v, input int n);
    serialIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input bit stopHigh, input int gapBits);
    @(negedge clk);
    driveBits(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) driveBits(d[i], BITCLK);
    driveBits((^d) ^ flipPar, BITCLK);
    if (stopHigh) driveBits(1'b1, BITCLK);
    else begin
      driveBits(1'b0, BITCLK / 2 + 8);
      driveBits(1'b1, BITCLK / 2 - 8);
    end
    driveBits(1'b1, gapBits * BITCLK);
  endtask

  task automatic testReset;
    repeat (5) @(negedge clk);
    check(rxValid == 1'b0 && rxData == 8'h00, "R1 outputs in reset", {rxValid, rxData}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(rxValid == 1'b0 && parityErr == 1'b0 && frameErr == 1'b0 && rxData == 8'h00,
          "R1 outputs after reset", {rxValid, parityErr, frameErr, rxData}, 0);
  endtask

  task automatic testByte(input logic [7:0] d);
    int n0;
    n0 = validCount;
    sendFrame(d, 1'b0, 1'b1, 2);
    check(validCount == n0 + 1, "R2/R9 one frame detected", validCount - n0, 1);
    check(lastData == d, "R4/R3 data bits LSB first", lastData, d);
    check(lastPar == 1'b0 && lastFrm == 1'b0, "R5/R6 clean frame flags", {lastPar, lastFrm}, 0);
  endtask

  task automatic testParityError;
    int n0;
    n0 = validCount;
    sendFrame(8'h37, 1'b1, 1'b1, 2);
    check(validCount == n0 + 1, "R5 frame with bad parity delivered", validCount - n0, 1);
    check(lastData == 8'h37, "R5 data with bad parity", lastData, 8'h37);
    check(lastPar == 1'b1, "R5 parityErr set", lastPar, 1);
    sendFrame(8'h36, 1'b0, 1'b1, 2);
    check(lastPar == 1'b0, "R5 parityErr cleared by good frame", lastPar, 0);
  endtask

  task automatic testFramingError;
    int n0;
    n0 = validCount;
    sendFrame(8'hC4, 1'b0, 1'b0, 3);
    check(validCount == n0 + 1, "R6 low stop still gives one pulse", validCount - n0, 1);
    check(lastFrm == 1'b1, "R6 frameErr set", lastFrm, 1);
    check(lastPar == 1'b0 && lastData == 8'hC4, "R6 data and parity", {lastPar, lastData}, 8'hC4);
  endtask

  task automatic testGlitch;
    int n0;
    logic [7:0] held;
    n0 = validCount;
    held = rxData;
    @(negedge clk);
    driveBits(1'b0, 12);
    driveBits(1'b1, 13 * BITCLK);
    check(validCount == n0, "R7 glitch gives no pulse", validCount - n0, 0);
    check(rxData == held, "R7 held data untouched", rxData, held);
  endtask

  task automatic testBackToBack;
    int n0;
    n0 = validCount;
    sendFrame(8'h12, 1'b0, 1'b1, 0);
    sendFrame(8'h34, 1'b0, 1'b1, 0);
    sendFrame(8'hC5, 1'b0, 1'b1, 2);
    check(validCount == n0 + 3, "R10 gapless frames all received", validCount - n0, 3);
    check(lastData == 8'hC5 && lastPar == 1'b0, "R10 last gapless byte", lastData, 8'hC5);
    check(holdErrs == 0, "R8 outputs held between pulses", holdErrs, 0);
    check(widthErrs == 0, "R8 valid is one cycle wide", widthErrs, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testByte(8'h55);
    testByte(8'hA3);
    testByte(8'h00);
    testByte(8'hFF);
    testByte(8'h80);
    testParityError();
    testFramingError();
    testGlitch();
    testBackToBack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule